// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master. A programmable prescaler divides the system clock into a slower module clock. The SCL low and high phases are then timed in module-clock ticks. Each phase lasts its programmed count plus a small fixed pad, and the pad depends on the prescale value. SCL is open-drain, so the block only ever pulls the line low or lets it go. The block also samples the SCL level on the wire. A slave that holds the line low after release stretches the high phase, because the high phase is not timed until the line is actually seen high.

Software sets up the block in three steps:
- Load the prescale, low-count and high-count values while the enable bit is clear.
- Set the enable bit.
- Pulse the run strobe to start clock generation.

Clearing the enable bit stops everything and returns SCL to released. A high count of zero means no clock is produced. START/STOP generation, data shifting and arbitration belong to other blocks.

Top module: `scl_clock_gen`

## Requirements
- R1: In the cycle after synchronous reset, `scl_drive_low` is 0 (line released) and `mod_tick` is 0.
- R2: While enabled, `mod_tick` pulses for one cycle every `psc_val`+1 system clock cycles.
- R3: In steady running with an unobstructed line, each SCL low phase (`scl_drive_low`=1) lasts (`low_count`+pad)×(`psc_val`+1) cycles.
- R4: In steady running with an unobstructed line, each SCL high phase (`scl_drive_low`=0) lasts (`high_count`+pad)×(`psc_val`+1) cycles.
- R5: With `FIXED_PAD`=0, the pad depends on the prescale value: 7 when `psc_val` is 0, 6 when it is 1, and 5 when it is 2 or more.
- R6: With `FIXED_PAD`=1, the pad is 6 whatever the prescale value.
- R7: While `high_count` is 0, `scl_drive_low` stays 0 and no clock is generated, even after a run strobe.
- R8: While `mod_en` is 0, `scl_drive_low` and `mod_tick` are 0 from the next cycle on.
- R9: After `mod_en` is set, no low phase begins until `run_strobe` is pulsed. The first low phase begins in the cycle after the strobe.
- R10: When `scl_drive_low` has been released and `scl_sense` is still 0, the high phase is not timed. Each cycle that the line is held low adds one cycle to the released period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Enable bit; 0 holds the generator in reset |
| run_strobe | input | 1 | One-cycle pulse that starts clock generation |
| psc_val | input | PSC_W | Prescale value; module clock = clk/(psc_val+1) |
| low_count | input | CNT_W | Programmed low-phase count |
| high_count | input | CNT_W | Programmed high-phase count; 0 disables SCL |
| scl_sense | input | 1 | SCL level sensed on the wire |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| mod_tick | output | 1 | One-cycle module-clock tick |

## Verification
The checker module asserts these properties on every cycle:
- the released state after reset;
- the hold while the enable bit is clear;
- the absence of clock output while the high count is zero;
- the spacing between module ticks;
- the rule that a released line sensed low cannot end the high phase.

Only the bench scenarios can show the exact phase lengths. These lengths depend on the pad chosen for each prescale value and for the fixed-pad variant. The bench also covers the point where generation starts after the run strobe and the exact length of a stretched high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_t;

  // Extra module-clock ticks added to each SCL phase.
  function automatic logic [2:0] phase_pad(input logic psc_zero,
                                           input logic psc_one,
                                           input logic fixed);
    if (fixed)         return 3'd6;
    else if (psc_zero) return 3'd7;
    else if (psc_one)  return 3'd6;
    else               return 3'd5;
  endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;
  logic             wrap;

  // Wrap also when psc shrank below the running count.
  assign wrap = (div_q >= psc);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= wrap ? '0 : div_q + 1'b1;
      tick  <= wrap;
    end
  end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int PSC_W     = 16,
  parameter int CNT_W     = 16,
  parameter bit FIXED_PAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             drive_low
);

  localparam int PW = CNT_W + 1;

  scl_phase_t    state_q, state_n;
  logic [PW-1:0] cnt_q, cnt_n;
  logic [PW-1:0] limit;
  logic [2:0]    pad;
  logic          high_zero;

  assign high_zero = (high_cnt == '0);

  generate
    if (FIXED_PAD) begin : g_fixed
      assign pad = phase_pad(1'b0, 1'b0, 1'b1);
    end else begin : g_scaled
      assign pad = phase_pad(psc == '0, psc == PSC_W'(1), 1'b0);
    end
  endgenerate

  // Last tick index of the current phase (pad >= 5, so no underflow).
  always_comb begin
    limit = ((state_q == PH_LOW) ? {1'b0, low_cnt} : {1'b0, high_cnt})
            + PW'(pad) - PW'(1);
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    unique case (state_q)
      PH_IDLE: begin
        if (run) begin
          state_n = PH_LOW;
          cnt_n   = '0;
        end
      end
      PH_LOW: begin
        if (tick) begin
          if (cnt_q == limit) begin
            state_n = PH_HIGH;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      PH_HIGH: begin
        // The high phase is timed only while the wire reads high.
        if (tick && scl_in) begin
          if (cnt_q == limit) begin
            state_n = PH_LOW;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
    if (!en || high_zero) begin
      state_n = PH_IDLE;
      cnt_n   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      drive_low <= 1'b0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      drive_low <= (state_n == PH_LOW);
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int PSC_W     = 16,
  parameter int CNT_W     = 16,
  parameter bit FIXED_PAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_en,
  input  logic             run_strobe,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_sense,
  output logic             scl_drive_low,
  output logic             mod_tick
);

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .en   (mod_en),
    .psc  (psc_val),
    .tick (mod_tick)
  );

  scl_phase_ctrl #(
    .PSC_W     (PSC_W),
    .CNT_W     (CNT_W),
    .FIXED_PAD (FIXED_PAD)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .en        (mod_en),
    .run       (run_strobe),
    .tick      (mod_tick),
    .psc       (psc_val),
    .low_cnt   (low_count),
    .high_cnt  (high_count),
    .scl_in    (scl_sense),
    .drive_low (scl_drive_low)
  );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mod_en,
  input logic             run_strobe,
  input logic [PSC_W-1:0] psc_val,
  input logic [CNT_W-1:0] high_count,
  input logic             scl_sense,
  input logic             scl_drive_low,
  input logic             mod_tick
);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!scl_drive_low && !mod_tick));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (!scl_drive_low && !mod_tick));

  // R7
  no_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (high_count == '0) |=> !scl_drive_low);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_tick && psc_val != '0) |=> !mod_tick);

  // R10
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !run_strobe && !scl_drive_low && !scl_sense) |=> !scl_drive_low);

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mod_en        (mod_en),
  .run_strobe    (run_strobe),
  .psc_val       (psc_val),
  .high_count    (high_count),
  .scl_sense     (scl_sense),
  .scl_drive_low (scl_drive_low),
  .mod_tick      (mod_tick)
);

// File: tb/tb_scl_clock_gen.sv
`timescale 1ns/1ps
module tb_scl_clock_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_en = 1'b0;
  logic        run_strobe = 1'b0;
  logic [15:0] psc_val = '0;
  logic [15:0] low_count = '0;
  logic [15:0] high_count = '0;
  logic        hold = 1'b0;
  logic        dl, tk, fx_dl, fx_tk;
  logic        line, fx_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign line    = !dl && !hold;
  assign fx_line = !fx_dl;

  scl_clock_gen dut (
    .clk(clk), .rst(rst), .mod_en(mod_en), .run_strobe(run_strobe),
    .psc_val(psc_val), .low_count(low_count), .high_count(high_count),
    .scl_sense(line), .scl_drive_low(dl), .mod_tick(tk)
  );

  scl_clock_gen #(.FIXED_PAD(1'b1)) dut_fx (
    .clk(clk), .rst(rst), .mod_en(mod_en), .run_strobe(run_strobe),
    .psc_val(psc_val), .low_count(low_count), .high_count(high_count),
    .scl_sense(fx_line), .scl_drive_low(fx_dl), .mod_tick(fx_tk)
  );

  // {psc, low, high}
  localparam logic [47:0] VEC [5] = '{
    {16'd0, 16'd3,  16'd2},
    {16'd1, 16'd4,  16'd3},
    {16'd2, 16'd2,  16'd1},
    {16'd5, 16'd1,  16'd1},
    {16'd0, 16'd10, 16'd20}
  };

  function automatic int pad_of(input int p, input bit fixed);
    if (fixed)       return 6;
    else if (p == 0) return 7;
    else if (p == 1) return 6;
    else             return 5;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sel(input bit fx);
    return fx ? fx_dl : dl;
  endfunction

  task automatic start(input int p, input int lo, input int hi);
    @(negedge clk);
    mod_en = 1'b0;
    psc_val = 16'(p); low_count = 16'(lo); high_count = 16'(hi);
    @(negedge clk);
    mod_en = 1'b1;
    @(negedge clk);
    run_strobe = 1'b1;
    @(negedge clk);
    run_strobe = 1'b0;
  endtask

  task automatic measure(input bit fx, output int lo, output int hi);
    lo = 0; hi = 0;
    while (sel(fx) != 1'b1) @(negedge clk);
    while (sel(fx) != 1'b0) @(negedge clk);
    while (sel(fx) != 1'b1) @(negedge clk);
    while (sel(fx) == 1'b1) begin lo++; @(negedge clk); end
    while (sel(fx) == 1'b0) begin hi++; @(negedge clk); end
  endtask

  initial begin
    int lo, hi, cnt, gap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drive_low", int'(dl), 0);
    check("R1 mod_tick", int'(tk), 0);
    rst = 1'b0;

    // R3 R4 R5: table of prescale/low/high settings
    for (int i = 0; i < 5; i++) begin
      int p, l, h, d;
      p = int'(VEC[i][47:32]); l = int'(VEC[i][31:16]); h = int'(VEC[i][15:0]);
      d = pad_of(p, 1'b0);
      start(p, l, h);
      measure(1'b0, lo, hi);
      check($sformatf("R3 R5 low psc=%0d", p), lo, (l + d) * (p + 1));
      check($sformatf("R4 R5 high psc=%0d", p), hi, (h + d) * (p + 1));
    end

    // R6: fixed-pad variant
    start(0, 3, 2);
    measure(1'b1, lo, hi);
    check("R6 low psc=0", lo, 9);
    check("R6 high psc=0", hi, 8);
    start(3, 3, 2);
    measure(1'b1, lo, hi);
    check("R6 low psc=3", lo, 36);
    check("R6 high psc=3", hi, 32);

    // R2: tick spacing psc=3
    start(3, 3, 2);
    while (tk != 1'b1) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (tk != 1'b1) begin gap++; @(negedge clk); end
    check("R2 tick period", gap, 4);

    // R8: enable cleared stops ticks and releases line
    @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (tk || dl) cnt++;
      @(negedge clk);
    end
    check("R8 activity while disabled", cnt, 0);

    // R9: enabled without run strobe stays released
    psc_val = 16'd0; low_count = 16'd3; high_count = 16'd2;
    mod_en = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (dl) cnt++;
      @(negedge clk);
    end
    check("R9 no low before run", cnt, 0);
    run_strobe = 1'b1;
    @(negedge clk);
    run_strobe = 1'b0;
    check("R9 low after run", int'(dl), 1);

    // R7: zero high count gives no clock
    start(0, 3, 0);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      if (dl) cnt++;
      @(negedge clk);
    end
    check("R7 no clock with high=0", cnt, 0);

    // R10: slave stretches the high phase (psc=0, low=3, high=2 -> high 9)
    start(0, 3, 2);
    while (dl != 1'b1) @(negedge clk);
    hold = 1'b1;
    while (dl != 1'b0) @(negedge clk);
    cnt = 1;
    repeat (5) begin @(negedge clk); cnt++; end
    hold = 1'b0;
    @(negedge clk);
    while (dl == 1'b0) begin cnt++; @(negedge clk); end
    check("R10 stretched high", cnt, 14);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule